// File: doc/BRIEF.md
# Key-Locked Pipelined Parameter Memory

This block holds a window of 28-bit parameter words behind a plain address and data bus with separate write and read strobes. A processing engine elsewhere in the chip uses these words. Software loads the words with ordinary bus writes. A write does not reach the array at once. It enters a two-stage staging pipeline, and each later accepted bus write moves the pipeline forward by one stage. A value therefore lands in storage only after two more writes have followed it.

A protection latch guards the window against stray writes. Software changes the latch with a two-write unlock sequence. The first write puts a key byte at a key address. The very next write puts a command byte at a control address. While the latch is set, every write into the window is dropped, and the dropped write does not move the pipeline. Reads are never blocked. The latch state can also be read back at the control address.

Top module: `keylock_param_mem`

## Requirements
- R1: After reset the latch is clear, every window word reads 0, and the control address 0xE7E3 reads 0x00.
- R2: The sequence arms only on a write whose full data equals 0xAD at address 0xE7FE. A write of any other value there does not arm it.
- R3: When the sequence is armed and the next write puts 0x80 at 0xE7E3, the latch is set. The control address then reads 0x80.
- R4: When the sequence is armed and the next write puts 0x00 at 0xE7E3, the latch is cleared. The control address then reads 0x00.
- R5: While the latch is set, a write into the window (0x4380 to 0x43BE, 63 words) changes no stored word. It also does not move the staging pipeline.
- R6: Each of the following leaves the latch unchanged and disarms the sequence: a write to another address between the key write and the control write, a value other than 0x00 or 0x80 at 0xE7E3, or a control write made without a preceding key.
- R7: Each write that is not dropped moves the pipeline one step. A window value becomes readable after exactly two further non-dropped writes, and this holds at both ends of the window.
- R8: A read of a word that still has a write pending returns the word's previous stored contents.
- R9: Reads are always served, with the data on rd_data one cycle after rd_en. Addresses outside the window and other than 0xE7E3 read 0.
- R10: A non-dropped write outside the window and other than the control sequence stores nothing. It still moves the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 16 | Bus address for both reads and writes |
| wr_data | input | 28 | Write data; control addresses use the low byte and compare the full word |
| rd_data | output | 28 | Read data, registered, valid the cycle after rd_en |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle. They also assume that addr and wr_data are stable and known whenever a strobe is high. The bench drives every operation as one strobed cycle on the falling edge, and never raises both strobes together. This keeps the stimulus inside those assumptions, including in the randomized phase, which mixes window writes, stray writes and key sequences.

// File: rtl/kpm_pkg.sv
// Package: shared widths and the pending-write record used by the
// staging pipeline and the storage array.
// Assumes: the window holds at most 64 words (6-bit index).
package kpm_pkg;
    localparam int DATA_W = 28;
    localparam int ADDR_W = 16;
    localparam int IDX_W  = 6;

    // One staged write: a valid flag, the word index and the data.
    typedef struct packed {
        logic              vld;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } pend_t;
endpackage

// File: rtl/kpm_keylock.sv
// Module: two-write unlock detector and protection latch.
// The first write must carry KEY_VAL at KEY_ADDR. The write right after it,
// if it targets LOCK_ADDR with ON_VAL or OFF_VAL, sets or clears the latch.
// Any other write disarms the detector.
// Assumes: wr_en is a single-cycle strobe, and addr/data are valid while it is high.
module kpm_keylock
    import kpm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 16'hE7FE,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 16'hE7E3,
    parameter logic [7:0]        KEY_VAL   = 8'hAD,
    parameter logic [7:0]        ON_VAL    = 8'h80,
    parameter logic [7:0]        OFF_VAL   = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              prot_o
);
    localparam logic [DATA_W-1:0] KEY_WORD = DATA_W'(KEY_VAL);
    localparam logic [DATA_W-1:0] ON_WORD  = DATA_W'(ON_VAL);
    localparam logic [DATA_W-1:0] OFF_WORD = DATA_W'(OFF_VAL);

    logic armed_q, prot_q;
    logic key_hit, lock_hit;

    // Decode whether the current write is a key write or a control write.
    always_comb begin
        key_hit  = (addr == KEY_ADDR) && (data == KEY_WORD);
        lock_hit = (addr == LOCK_ADDR);
    end

    // Track the armed state and update the latch on an armed control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            prot_q  <= 1'b0;
        end else if (wr_en) begin
            armed_q <= key_hit;
            if (armed_q && lock_hit) begin
                if (data == ON_WORD)       prot_q <= 1'b1;
                else if (data == OFF_WORD) prot_q <= 1'b0;
            end
        end
    end

    assign prot_o = prot_q;

    // R2: the detector arms only on a write that carries the key
    a_r2_arm_on_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_q) |-> $past(wr_en && key_hit));

    // R6: the latch moves only on an armed control write
    a_r6_latch_keyed: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_q != $past(prot_q)) |-> $past(armed_q && wr_en && lock_hit));
endmodule

// File: rtl/kpm_stage_pipe.sv
// Module: write staging pipeline with PIPE_STAGES stages.
// Each advance shifts the entries one stage along. The oldest entry is
// offered for commit on that same advance, if it is valid.
// Assumes: adv_i is high for at most one cycle per bus write.
module kpm_stage_pipe
    import kpm_pkg::*;
#(
    parameter int PIPE_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv_i,
    input  pend_t ent_i,
    output logic  commit_o,
    output pend_t commit_ent_o
);
    pend_t stg_q [PIPE_STAGES];

    // Stage 0 loads the incoming write record on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n)     stg_q[0] <= '0;
        else if (adv_i) stg_q[0] <= ent_i;
    end

    // Later stages copy the stage before them on each advance.
    for (genvar g = 1; g < PIPE_STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)     stg_q[g] <= '0;
            else if (adv_i) stg_q[g] <= stg_q[g-1];
        end
    end

    // Offer the oldest entry for commit.
    always_comb begin
        commit_ent_o = stg_q[PIPE_STAGES-1];
        commit_o     = adv_i && stg_q[PIPE_STAGES-1].vld;
    end

    // R5: without an advance the oldest entry holds still
    a_r5_hold_without_adv: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(stg_q[PIPE_STAGES-1]));

    // R7: a commit happens only on an advancing write
    a_r7_commit_on_adv: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> adv_i);
endmodule

// File: rtl/kpm_store.sv
// Module: storage array of WORDS parameter words, cleared on reset.
// It has one write port from the pipeline commit and one combinational read port.
// Assumes: write indices are always below WORDS.
module kpm_store
    import kpm_pkg::*;
#(
    parameter int WORDS = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_word_o
);
    logic [DATA_W-1:0] mem_q [WORDS];

    // Clear every word on reset, otherwise write the committed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[wr_idx_i] <= wr_data_i;
        end
    end

    // Return the addressed word, or zero for an index past the end.
    always_comb begin
        rd_word_o = '0;
        if (int'(rd_idx_i) < WORDS) rd_word_o = mem_q[rd_idx_i];
    end

    // R7: commits always target a word inside the window
    a_r7_commit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (int'(wr_idx_i) < WORDS));
endmodule

// File: rtl/keylock_param_mem.sv
// Module: top of the key-locked parameter memory.
// It decodes the window and the control address, drops window writes while
// the latch is set, stages accepted writes and serves registered reads.
// Assumes: wr_en and rd_en are never high together.
module keylock_param_mem
    import kpm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE    = 16'h4380,
    parameter int                WIN_WORDS   = 63,
    parameter int                PIPE_STAGES = 2,
    parameter logic [ADDR_W-1:0] KEY_ADDR    = 16'hE7FE,
    parameter logic [ADDR_W-1:0] LOCK_ADDR   = 16'hE7E3,
    parameter logic [7:0]        KEY_VAL     = 8'hAD,
    parameter logic [7:0]        ON_VAL      = 8'h80,
    parameter logic [7:0]        OFF_VAL     = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [15:0]       addr,
    input  logic [27:0]       wr_data,
    output logic [27:0]       rd_data
);
    localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + ADDR_W'(WIN_WORDS - 1);

    logic              prot;
    logic              win_hit;
    logic [IDX_W-1:0]  idx;
    logic              adv;
    pend_t             ent;
    logic              commit;
    pend_t             commit_ent;
    logic [DATA_W-1:0] store_word;
    logic [DATA_W-1:0] rd_q;

    // Decode the window, and decide whether a write is accepted.
    always_comb begin
        win_hit  = (addr >= WIN_BASE) && (addr <= WIN_LAST);
        idx      = IDX_W'(addr - WIN_BASE);
        adv      = wr_en && !(win_hit && prot);
        ent.vld  = win_hit;
        ent.idx  = idx;
        ent.data = wr_data;
    end

    kpm_keylock #(
        .KEY_ADDR(KEY_ADDR), .LOCK_ADDR(LOCK_ADDR),
        .KEY_VAL(KEY_VAL), .ON_VAL(ON_VAL), .OFF_VAL(OFF_VAL)
    ) u_lock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .addr(addr), .data(wr_data), .prot_o(prot)
    );

    kpm_stage_pipe #(.PIPE_STAGES(PIPE_STAGES)) u_pipe (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .ent_i(ent),
        .commit_o(commit), .commit_ent_o(commit_ent)
    );

    kpm_store #(.WORDS(WIN_WORDS)) u_store (
        .clk(clk), .rst_n(rst_n), .we_i(commit),
        .wr_idx_i(commit_ent.idx), .wr_data_i(commit_ent.data),
        .rd_idx_i(idx), .rd_word_o(store_word)
    );

    // Register the read result: window word, latch state, or zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            if (win_hit)                rd_q <= store_word;
            else if (addr == LOCK_ADDR) rd_q <= DATA_W'(prot ? ON_VAL : OFF_VAL);
            else                        rd_q <= '0;
        end
    end

    assign rd_data = rd_q;

    // R5: a window write under protection never produces a commit
    a_r5_no_commit_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && win_hit && prot) |-> !commit);

    // R9: the read data changes only after a read strobe
    a_r9_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/keylock_param_mem_test.sv
// Bench: a behavioural reference model (queue-based pipeline, flat array,
// latch and armed flags) checked against every read the bench issues.
module keylock_param_mem_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [27:0] wr_data = '0;
    logic [27:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic [27:0] m_mem [63];
    bit          m_prot;
    bit          m_armed;
    bit          q_vld [$];
    int          q_idx [$];
    logic [27:0] q_dat [$];

    always #5 clk = ~clk;

    keylock_param_mem uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic bit in_win(input logic [15:0] a);
        return (a >= 16'h4380) && (a <= 16'h43BE);
    endfunction

    // Model one bus write.
    task automatic model_wr(input logic [15:0] a, input logic [27:0] d);
        bit was_armed = m_armed;
        if (!(in_win(a) && m_prot)) begin
            q_vld.push_back(in_win(a));
            q_idx.push_back(int'(a) - 'h4380);
            q_dat.push_back(d);
            if (q_vld.size() > 2) begin
                bit v = q_vld.pop_front();
                int i = q_idx.pop_front();
                logic [27:0] x = q_dat.pop_front();
                if (v) m_mem[i] = x;
            end
        end
        m_armed = (a == 16'hE7FE) && (d == 28'hAD);
        if (was_armed && a == 16'hE7E3) begin
            if (d == 28'h80) m_prot = 1'b1;
            else if (d == 28'h00) m_prot = 1'b0;
        end
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [27:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        model_wr(a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [15:0] a, input string req);
        logic [27:0] exp;
        if (in_win(a))          exp = m_mem[int'(a) - 'h4380];
        else if (a == 16'hE7E3) exp = m_prot ? 28'h80 : 28'h00;
        else                    exp = '0;
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        n_chk++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rd_data, exp);
        end
    endtask

    initial begin
        #2000000;
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 63; i++) m_mem[i] = '0;
        m_prot = 0; m_armed = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R9 reset state and outside reads
        do_rd(16'h4380, "R1");
        do_rd(16'h43BE, "R1");
        do_rd(16'hE7E3, "R1");
        do_rd(16'h1234, "R9");

        // R8 / R7 pipeline
        do_wr(16'h4380, 28'hA1A1A1);
        do_rd(16'h4380, "R8");
        do_wr(16'h4381, 28'hB2B2B2);
        do_rd(16'h4380, "R8");
        do_wr(16'h4382, 28'hC3C3C3);
        do_rd(16'h4380, "R7");
        // R10 out-of-window write advances
        do_wr(16'h0010, 28'h5);
        do_rd(16'h4381, "R10");
        do_rd(16'h0010, "R10");

        // R3 lock on
        do_wr(16'hE7FE, 28'hAD);
        do_wr(16'hE7E3, 28'h80);
        do_rd(16'hE7E3, "R3");
        do_rd(16'h4382, "R7");
        // R5 discarded, no advance
        do_wr(16'h4385, 28'h777);
        do_rd(16'h4385, "R5");
        do_wr(16'h0020, 28'h1);
        do_wr(16'h0021, 28'h2);
        do_rd(16'h4385, "R5");

        // R6 disarm cases
        do_wr(16'hE7FE, 28'hAD);
        do_wr(16'h1111, 28'h0);
        do_wr(16'hE7E3, 28'h00);
        do_rd(16'hE7E3, "R6");
        do_wr(16'hE7FE, 28'hAD);
        do_wr(16'hE7E3, 28'h55);
        do_wr(16'hE7E3, 28'h00);
        do_rd(16'hE7E3, "R6");

        // R4 unlock
        do_wr(16'hE7FE, 28'hAD);
        do_wr(16'hE7E3, 28'h00);
        do_rd(16'hE7E3, "R4");

        // R2 wrong key value does not arm
        do_wr(16'hE7FE, 28'hAE);
        do_wr(16'hE7E3, 28'h80);
        do_rd(16'hE7E3, "R2");
        do_wr(16'hE7FE, 28'h1AD);
        do_wr(16'hE7E3, 28'h80);
        do_rd(16'hE7E3, "R2");

        // R7 top of window
        do_wr(16'h43BE, 28'hFEDCBA9);
        do_wr(16'h0001, 28'h0);
        do_rd(16'h43BE, "R8");
        do_wr(16'h0002, 28'h0);
        do_rd(16'h43BE, "R7");

        // R7 randomized mix against the model
        for (int n = 0; n < 400; n++) begin
            int k = $urandom_range(0, 9);
            logic [15:0] a = 16'h4380 + 16'($urandom_range(0, 62));
            if (k < 4)       do_wr(a, 28'($urandom()));
            else if (k < 7)  do_rd(a, "R7");
            else if (k == 7) do_wr(16'h2000, 28'($urandom()));
            else if (k == 8) begin
                do_wr(16'hE7FE, 28'hAD);
                do_wr(16'hE7E3, ($urandom_range(0, 1) == 1) ? 28'h80 : 28'h00);
                do_rd(16'hE7E3, "R3");
            end else         do_rd(16'hE7E3, "R4");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule